// File: doc/BRIEF.md
# Transition-Limiting Bus Inversion Encoder

This block sits in front of two 36-bit column-driver data buses, one carrying odd pixels and one carrying even pixels. For each bus it counts how many bits of the next word would flip relative to the word that bus last put on its wires. When that count is too high, it sends the complement of the word and raises a polarity line for that bus. The column driver uses the polarity line to undo the inversion. This roughly halves the worst-case number of simultaneously switching outputs.

The two buses are handled as separate lanes. Each lane has its own valid strobe, its own stored history and its own polarity output. This lets a skewed output arrangement, where the buses are loaded at different times, run each lane on its own schedule.

A global enable turns the feature on or off. A single-bus layout indication forces the feature off on both lanes, whatever the enable says. Data leaves the block one clock after it is accepted.

Top module: `bus_inv_encoder`

## Requirements
- R1: While rst_n is low, both data outputs are all zeros and both polarity outputs are 0. The stored previous word of each lane is therefore zero when reset is released.
- R2: When a lane's valid is high, pol_en is 1 and single_bus is 0, an input that differs from the lane's currently driven word in more than 18 of 36 bits appears inverted on the next clock, with that lane's polarity output at 1.
- R3: Under the same conditions, a difference of 18 bits or fewer (18 included) leaves the word unchanged on the next clock, with polarity 0.
- R4: The toggle count is taken against the word actually driven on the output, after any inversion, and not against the previous raw input.
- R5: With pol_en at 0, an accepted word is driven unchanged with polarity 0. The driven word remains the history used once the feature is enabled again.
- R6: With single_bus at 1, both lanes drive accepted words unchanged with polarity 0, even when pol_en is 1.
- R7: While a lane's valid is low, that lane's data and polarity outputs hold their values.
- R8: The odd and even lanes keep separate histories and are loaded only by their own valid strobes.
- R9: For every accepted word, the output complemented when polarity is 1 equals the accepted input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pol_en | input | 1 | Enables inversion encoding |
| single_bus | input | 1 | Single-bus layout indication, forces encoding off |
| odd_vld | input | 1 | Odd lane word valid |
| odd_data | input | 36 | Odd lane input word |
| even_vld | input | 1 | Even lane word valid |
| even_data | input | 36 | Even lane input word |
| odd_q | output | 36 | Odd lane driven word |
| odd_pol | output | 1 | Odd lane polarity, 1 = word inverted |
| even_q | output | 36 | Even lane driven word |
| even_pol | output | 1 | Even lane polarity, 1 = word inverted |

## Verification
The stored history of a lane is its output register. A wrong history value therefore shows up on the very next accepted word, as a polarity decision that disagrees with the toggle count against the visible output. A sequence whose raw-input and driven-word histories differ brings this out within one cycle. A lane that is loaded by the wrong strobe shows up as a change on an output whose valid stayed low, on the clock that follows.

// File: rtl/bus_inv_encoder.sv
module bus_inv_encoder #(
  parameter int W     = 36,
  parameter int LIMIT = W / 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pol_en,
  input  logic         single_bus,
  input  logic         odd_vld,
  input  logic [W-1:0] odd_data,
  input  logic         even_vld,
  input  logic [W-1:0] even_data,
  output logic [W-1:0] odd_q,
  output logic         odd_pol,
  output logic [W-1:0] even_q,
  output logic         even_pol
);
  localparam int CW = $clog2(W + 1);

  function automatic logic [CW-1:0] toggles(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [CW-1:0] n;
    n = '0;
    for (int i = 0; i < W; i++) n = n + CW'(a[i] ^ b[i]);
    return n;
  endfunction

  logic         vld  [2];
  logic [W-1:0] din  [2];
  logic [W-1:0] qreg [2];
  logic         preg [2];

  assign vld[0] = odd_vld;
  assign vld[1] = even_vld;
  assign din[0] = odd_data;
  assign din[1] = even_data;
  assign odd_q    = qreg[0];
  assign odd_pol  = preg[0];
  assign even_q   = qreg[1];
  assign even_pol = preg[1];

  wire active = pol_en & ~single_bus;

  for (genvar g = 0; g < 2; g++) begin : g_lane
    wire flip = active & (toggles(din[g], qreg[g]) > CW'(LIMIT));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        qreg[g] <= '0;
        preg[g] <= 1'b0;
      end else if (vld[g]) begin
        qreg[g] <= flip ? ~din[g] : din[g];
        preg[g] <= flip;
      end
    end
  end
endmodule

// File: rtl/bus_inv_encoder_chk.sv
module bus_inv_encoder_chk #(
  parameter int W     = 36,
  parameter int LIMIT = W / 2
) (
  input logic         clk,
  input logic         rst_n,
  input logic         pol_en,
  input logic         single_bus,
  input logic         vld,
  input logic [W-1:0] din,
  input logic [W-1:0] q,
  input logic         pol
);
  AST_FEW_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && pol_en && !single_bus) |=> ($countones(q ^ $past(q)) <= LIMIT)); // R2
  AST_DISABLED_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && !pol_en) |=> (!pol && q == $past(din))); // R5
  AST_SINGLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && single_bus) |=> (!pol && q == $past(din))); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !vld |=> ($stable(q) && $stable(pol))); // R7
  AST_RECOVERABLE: assert property (@(posedge clk) disable iff (!rst_n)
    vld |=> ((pol ? ~q : q) == $past(din))); // R9
endmodule

bind bus_inv_encoder bus_inv_encoder_chk #(.W(W), .LIMIT(LIMIT)) u_chk_odd (
  .clk(clk), .rst_n(rst_n), .pol_en(pol_en), .single_bus(single_bus),
  .vld(odd_vld), .din(odd_data), .q(odd_q), .pol(odd_pol));

bind bus_inv_encoder bus_inv_encoder_chk #(.W(W), .LIMIT(LIMIT)) u_chk_even (
  .clk(clk), .rst_n(rst_n), .pol_en(pol_en), .single_bus(single_bus),
  .vld(even_vld), .din(even_data), .q(even_q), .pol(even_pol));

// File: tb/tb_bus_inv_encoder.sv
module tb_bus_inv_encoder;
  logic clk = 1'b0;
  logic rst_n, pol_en, single_bus, odd_vld, even_vld, odd_pol, even_pol;
  logic [35:0] odd_data, even_data, odd_q, even_q;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bus_inv_encoder dut (
    .clk(clk), .rst_n(rst_n), .pol_en(pol_en), .single_bus(single_bus),
    .odd_vld(odd_vld), .odd_data(odd_data), .even_vld(even_vld), .even_data(even_data),
    .odd_q(odd_q), .odd_pol(odd_pol), .even_q(even_q), .even_pol(even_pol));

  // {en, single, vld, data, exp_q, exp_pol} for the odd lane
  localparam logic [75:0] VEC [0:9] = '{
    {1'b1, 1'b0, 1'b1, 36'h0_0000_0000, 36'h0_0000_0000, 1'b0},
    {1'b1, 1'b0, 1'b1, 36'hF_FFFF_FFFF, 36'h0_0000_0000, 1'b1},
    {1'b1, 1'b0, 1'b1, 36'h0_0007_FFFF, 36'hF_FFF8_0000, 1'b1},
    {1'b1, 1'b0, 1'b1, 36'hF_FFFB_FFFF, 36'hF_FFFB_FFFF, 1'b0},
    {1'b1, 1'b0, 1'b0, 36'h0_0000_0000, 36'hF_FFFB_FFFF, 1'b0},
    {1'b0, 1'b0, 1'b1, 36'h0_0000_0000, 36'h0_0000_0000, 1'b0},
    {1'b0, 1'b0, 1'b1, 36'hF_FFFF_FFFF, 36'hF_FFFF_FFFF, 1'b0},
    {1'b1, 1'b0, 1'b1, 36'h0_0000_0000, 36'hF_FFFF_FFFF, 1'b1},
    {1'b1, 1'b0, 1'b1, 36'h0_0000_0001, 36'hF_FFFF_FFFE, 1'b1},
    {1'b1, 1'b1, 1'b1, 36'h0_0000_0000, 36'h0_0000_0000, 1'b0}};
  localparam string TAG [0:9] = '{"R3", "R2", "R2", "R3", "R7", "R5", "R5", "R5", "R4", "R6"};

  task automatic check(string req, logic [35:0] q, logic p, logic [35:0] eq, logic ep);
    checks++;
    if (q !== eq || p !== ep) begin
      errors++;
      $display("FAIL %s: got q=%h pol=%b, expected q=%h pol=%b", req, q, p, eq, ep);
    end
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pol_en = 1'b1; single_bus = 1'b0;
    odd_vld = 1'b1; even_vld = 1'b1;
    odd_data = '1; even_data = '1;
    step; step;
    check("R1", odd_q, odd_pol, 36'h0, 1'b0);
    check("R1", even_q, even_pol, 36'h0, 1'b0);
    rst_n = 1'b1; even_vld = 1'b0;

    for (int i = 0; i < 10; i++) begin
      pol_en = VEC[i][75]; single_bus = VEC[i][74]; odd_vld = VEC[i][73];
      odd_data = VEC[i][72:37];
      step;
      check(TAG[i], odd_q, odd_pol, VEC[i][36:1], VEC[i][0]);
    end
    // R8: the even lane never saw a valid, so it is still at its reset value
    check("R8", even_q, even_pol, 36'h0, 1'b0);

    // R8: load the even lane only; odd must hold its last value
    single_bus = 1'b0; pol_en = 1'b1; odd_vld = 1'b0; even_vld = 1'b1;
    even_data = 36'h0_FFFF_FFFF;
    step;
    check("R8", even_q, even_pol, 36'hF_0000_0000, 1'b1);
    check("R8", odd_q, odd_pol, 36'h0, 1'b0);

    // R6: single-bus mode bypasses the even lane as well
    single_bus = 1'b1; even_data = 36'h0_0000_0000;
    step;
    check("R6", even_q, even_pol, 36'h0, 1'b0);

    // R2/R3 at the boundary on the even lane: 19 then 18 toggles from zero
    single_bus = 1'b0; even_data = 36'h0_0007_FFFF;
    step;
    check("R2", even_q, even_pol, 36'hF_FFF8_0000, 1'b1);
    even_data = 36'hF_FFF8_0000 ^ 36'h0_0003_FFFF;
    step;
    check("R3", even_q, even_pol, 36'hF_FFFB_FFFF, 1'b0);

    // R1: reset in the middle of a run clears both lanes
    rst_n = 1'b0;
    step;
    check("R1", even_q, even_pol, 36'h0, 1'b0);
    check("R1", odd_q, odd_pol, 36'h0, 1'b0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule